// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-purpose register store of a processor core in which the physical register that an architectural index reaches depends on the processor mode in force. Two read ports and one write port each take a 4-bit architectural index. A 5-bit mode input chooses the bank. Index 15, the program counter, lives outside this file. It reads as zero here, and writes to it are dropped.

Indices 0 to 7 are common to every mode. Indices 8 to 12 have one private copy for the fast-interrupt mode and one copy shared by every other mode. Indices 13 (stack pointer) and 14 (link register) have a private copy for each of the five exception modes plus one copy shared by user and system mode. That gives 30 physical words here, or 31 with the external program counter. The hardware gives indices 13 and 14 no special behaviour on the normal ports.

A second write port serves exception entry. It writes the link register of an explicitly named mode, whatever the current mode is, so the return address can be banked in the same cycle that the mode changes.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears every physical register to zero, and writes in a reset cycle have no effect.
- R2: Indices 0 to 7 reach the same physical register in every mode value.
- R3: Indices 8 to 12 reach a private copy in fast-interrupt mode (5'b10001) and one shared copy in every other mode value.
- R4: Indices 13 and 14 reach a separate copy for each of: user/system, fast-interrupt (5'b10001), interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011).
- R5: System mode (5'b11111) reaches exactly the user-mode (5'b10000) registers, and any mode value that is not one of the seven listed encodings also reaches the user bank.
- R6: Reads are combinational. A read in the same cycle as a write to that register returns the old value, and the new value is visible after the clock edge.
- R7: Index 15 always reads as zero, and a write to index 15 changes no register.
- R8: When exc_wr_en is high, index 14 of the bank selected by exc_mode is written with exc_wr_data at the clock edge, independent of the current mode.
- R9: When the exception write and the normal write hit the same physical register in one cycle, the exception value is stored. When they hit different registers, both are stored.
- R10: The two read ports are independent and each returns the register its own index selects under the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 5 | Current processor mode, selects the bank |
| rd_a_idx | input | 4 | Architectural index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Architectural index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write architectural index |
| wr_data | input | 32 | Normal write data |
| exc_wr_en | input | 1 | Exception link-register write enable |
| exc_mode | input | 5 | Mode whose link register the exception port writes |
| exc_wr_data | input | 32 | Exception write data |

## Verification
The assertions assume that mode and the read indices may change every cycle, that any 5-bit mode value may appear, and that both write ports may be active together. The stability assertion assumes only that nothing writes while the read index and the mode stay the same. The stimulus draws modes mostly from the seven valid encodings and sometimes from an arbitrary 5-bit value. It draws indices across all sixteen values, including 15, and turns on both write ports together often enough to produce same-register collisions. Directed sequences before the random phase cover every bank, the system/user alias, the reserved mode values and the write-priority cases.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

  // Architectural layout of the banked store
  localparam int IDX_W     = 4;
  localparam int MODE_W    = 5;
  localparam int N_SHARED  = 8;   // indices 0..7, one copy
  localparam int N_FBANKED = 5;   // indices 8..12, two copies
  localparam int N_BANKS   = 6;   // copies of indices 13 and 14
  localparam int IDX_SP    = N_SHARED + N_FBANKED;      // 13
  localparam int IDX_LR    = IDX_SP + 1;                // 14
  localparam int BASE_FIQ  = N_SHARED + N_FBANKED;      // 13
  localparam int BASE_SP   = BASE_FIQ + N_FBANKED;      // 18
  localparam int BASE_LR   = BASE_SP + N_BANKS;         // 24
  localparam int N_PHYS    = BASE_LR + N_BANKS;         // 30
  localparam int PHYS_W    = $clog2(N_PHYS);

  // Mode encodings
  localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;   // user, system and reserved values
    endcase
  endfunction

endpackage

// File: rtl/bank_mode_decode.sv
module bank_mode_decode
  import banked_regfile_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);

  always_comb begin
    bank_o = mode_to_bank(mode_i);
  end

endmodule

// File: rtl/bank_index_map.sv
module bank_index_map
  import banked_regfile_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  bank_e             bank_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              hit_o
);

  localparam int LO_END = N_SHARED;
  localparam int HI_END = N_SHARED + N_FBANKED;

  logic [PHYS_W-1:0] idx_ext;
  logic [PHYS_W-1:0] bank_ext;
  logic [PHYS_W-1:0] fiq_off;

  always_comb begin
    idx_ext  = PHYS_W'(idx_i);
    bank_ext = PHYS_W'(bank_i);
    fiq_off  = (bank_i == BK_FIQ) ? PHYS_W'(N_FBANKED) : '0;
    hit_o    = 1'b1;
    phys_o   = '0;
    if (int'(idx_i) < LO_END) begin
      phys_o = idx_ext;
    end else if (int'(idx_i) < HI_END) begin
      phys_o = idx_ext + fiq_off;
    end else if (int'(idx_i) == IDX_SP) begin
      phys_o = PHYS_W'(BASE_SP) + bank_ext;
    end else if (int'(idx_i) == IDX_LR) begin
      phys_o = PHYS_W'(BASE_LR) + bank_ext;
    end else begin
      hit_o  = 1'b0;   // program counter slot, not held here
    end
  end

endmodule

// File: rtl/bank_rf_store.sv
module bank_rf_store
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_RD   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wa_en,
  input  logic [PHYS_W-1:0]             wa_phys,
  input  logic [DATA_W-1:0]             wa_data,
  input  logic                          wb_en,
  input  logic [PHYS_W-1:0]             wb_phys,
  input  logic [DATA_W-1:0]             wb_data,
  input  logic [N_RD-1:0][PHYS_W-1:0]   rd_phys,
  input  logic [N_RD-1:0]               rd_hit,
  output logic [N_RD-1:0][DATA_W-1:0]   rd_data
);

  logic [DATA_W-1:0] mem [N_PHYS];

  // Port B is written last so it wins a collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_PHYS; i++) begin
        mem[i] <= '0;
      end
    end else begin
      if (wa_en) mem[wa_phys] <= wa_data;
      if (wb_en) mem[wb_phys] <= wb_data;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    always_comb begin
      rd_data[p] = rd_hit[p] ? mem[rd_phys[p]] : '0;
    end
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              exc_wr_en,
  input  logic [4:0]        exc_mode,
  input  logic [DATA_W-1:0] exc_wr_data
);

  localparam int N_RD = 2;

  bank_e cur_bank;
  bank_e exc_bank;

  bank_mode_decode i_cur_dec (.mode_i(mode),     .bank_o(cur_bank));
  bank_mode_decode i_exc_dec (.mode_i(exc_mode), .bank_o(exc_bank));

  // Read address mapping, one map per port
  logic [N_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [N_RD-1:0][PHYS_W-1:0] rd_phys;
  logic [N_RD-1:0]             rd_hit;
  logic [N_RD-1:0][DATA_W-1:0] rd_data;

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar p = 0; p < N_RD; p++) begin : g_rmap
    bank_index_map i_map (
      .idx_i  (rd_idx[p]),
      .bank_i (cur_bank),
      .phys_o (rd_phys[p]),
      .hit_o  (rd_hit[p])
    );
  end

  // Normal write mapping under the current mode
  logic [PHYS_W-1:0] wr_phys;
  logic              wr_hit;

  bank_index_map i_wmap (
    .idx_i  (wr_idx),
    .bank_i (cur_bank),
    .phys_o (wr_phys),
    .hit_o  (wr_hit)
  );

  // Exception write always targets the link register of exc_mode
  logic [PHYS_W-1:0] exc_phys;
  logic              exc_hit;

  bank_index_map i_emap (
    .idx_i  (IDX_W'(IDX_LR)),
    .bank_i (exc_bank),
    .phys_o (exc_phys),
    .hit_o  (exc_hit)
  );

  bank_rf_store #(
    .DATA_W (DATA_W),
    .N_RD   (N_RD)
  ) i_store (
    .clk     (clk),
    .rst     (rst),
    .wa_en   (wr_en & wr_hit),
    .wa_phys (wr_phys),
    .wa_data (wr_data),
    .wb_en   (exc_wr_en & exc_hit),
    .wb_phys (exc_phys),
    .wb_data (exc_wr_data),
    .rd_phys (rd_phys),
    .rd_hit  (rd_hit),
    .rd_data (rd_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        mode,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              exc_wr_en,
  input logic [4:0]        exc_mode,
  input logic [DATA_W-1:0] exc_wr_data
);

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= !rst;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rd_a_data == '0 && rd_b_data == '0));

  // R2
  shared_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx < 4'd8) |=>
      (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

  // R6
  read_stable_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    (!$past(wr_en) && !$past(exc_wr_en) && $stable(rd_a_idx) && $stable(mode))
      |-> $stable(rd_a_data));

  // R7
  pc_slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == 4'hF) |-> (rd_a_data == '0));

  // R7
  pc_slot_zero_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == 4'hF) |-> (rd_b_data == '0));

  // R8 R9
  exc_link_write_chk: assert property (@(posedge clk) disable iff (rst)
    exc_wr_en |=>
      (!(rd_b_idx == 4'd14 && mode_to_bank(mode) == mode_to_bank($past(exc_mode)))
       || rd_b_data == $past(exc_wr_data)));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

  localparam int DW = 32;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111;

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    mode;
  logic [3:0]    rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data, exc_wr_data;
  logic          wr_en, exc_wr_en;
  logic [4:0]    exc_mode;

  always #10 clk = ~clk;

  banked_regfile #(.DATA_W(DW)) i_banked_regfile (
    .clk(clk), .rst(rst), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .exc_wr_en(exc_wr_en), .exc_mode(exc_mode), .exc_wr_data(exc_wr_data)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference model built from the requirements
  logic [DW-1:0] m_lo [8];
  logic [DW-1:0] m_hi [2][5];
  logic [DW-1:0] m_sp [6];
  logic [DW-1:0] m_lr [6];

  logic [4:0] all_modes [7] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};

  function automatic int bnk(input logic [4:0] m);
    case (m)
      M_FIQ:   return 1;
      M_IRQ:   return 2;
      M_SVC:   return 3;
      M_ABT:   return 4;
      M_UND:   return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [DW-1:0] mrd(input logic [4:0] m, input logic [3:0] i);
    if (i < 8)        return m_lo[i];
    else if (i < 13)  return m_hi[bnk(m) == 1 ? 1 : 0][i - 8];
    else if (i == 13) return m_sp[bnk(m)];
    else if (i == 14) return m_lr[bnk(m)];
    else              return '0;
  endfunction

  task automatic mwr(input logic [4:0] m, input logic [3:0] i, input logic [DW-1:0] d);
    if (i < 8)        m_lo[i] = d;
    else if (i < 13)  m_hi[bnk(m) == 1 ? 1 : 0][i - 8] = d;
    else if (i == 13) m_sp[bnk(m)] = d;
    else if (i == 14) m_lr[bnk(m)] = d;
  endtask

  task automatic mclear();
    for (int i = 0; i < 8; i++) m_lo[i] = '0;
    for (int i = 0; i < 5; i++) begin m_hi[0][i] = '0; m_hi[1][i] = '0; end
    for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; end
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check reads before the edge, then commit to the model.
  task automatic cyc(input string tag, input logic [4:0] m,
                     input logic [3:0] ia, input logic [3:0] ib,
                     input logic we, input logic [3:0] wi, input logic [DW-1:0] wd,
                     input logic ee, input logic [4:0] em, input logic [DW-1:0] ed);
    @(negedge clk);
    mode = m; rd_a_idx = ia; rd_b_idx = ib;
    wr_en = we; wr_idx = wi; wr_data = wd;
    exc_wr_en = ee; exc_mode = em; exc_wr_data = ed;
    #2;
    chk({tag, " port A"}, rd_a_data, mrd(m, ia));
    chk({tag, " port B"}, rd_b_data, mrd(m, ib));
    @(posedge clk);
    #1;
    if (we) mwr(m, wi, wd);
    if (ee) mwr(em, 4'd14, ed);
  endtask

  task automatic rd(input string tag, input logic [4:0] m, input logic [3:0] ia, input logic [3:0] ib);
    cyc(tag, m, ia, ib, 1'b0, 4'd0, '0, 1'b0, M_USR, '0);
  endtask

  task automatic wr(input string tag, input logic [4:0] m, input logic [3:0] wi, input logic [DW-1:0] wd);
    cyc(tag, m, 4'd0, 4'd0, 1'b1, wi, wd, 1'b0, M_USR, '0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; mode = M_USR; rd_a_idx = '0; rd_b_idx = '0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    exc_wr_en = 1'b0; exc_mode = M_USR; exc_wr_data = '0;
    mclear();
    repeat (3) @(posedge clk);
    // R1: write attempted during reset is dropped
    @(negedge clk); wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'hBAD0_0001;
    @(negedge clk); rst = 1'b0; wr_en = 1'b0;

    // R1: every register of every bank reads zero
    foreach (all_modes[k])
      for (int i = 0; i < 16; i += 2) rd("R1 reset state", all_modes[k], 4'(i), 4'(i + 1));

    // R7: write to index 15 is dropped
    cyc("R7 write pc slot", M_USR, 4'd15, 4'd15, 1'b1, 4'd15, 32'hFFFF_FFFF, 1'b0, M_USR, '0);
    for (int i = 0; i < 16; i += 2) rd("R7 no side effect", M_USR, 4'(i), 4'(i + 1));

    // R2: low indices shared
    wr("R2 write", M_IRQ, 4'd3, 32'h0303_0303);
    wr("R2 write", M_FIQ, 4'd7, 32'h0707_0707);
    foreach (all_modes[k]) rd("R2 shared", all_modes[k], 4'd3, 4'd7);
    rd("R2 shared reserved mode", 5'b00101, 4'd3, 4'd7);

    // R3: indices 8..12 banked for fast interrupt only
    for (int i = 8; i < 13; i++) begin
      wr("R3 write fiq", M_FIQ, 4'(i), 32'hF1F0_0000 + i);
      wr("R3 write usr", M_SVC, 4'(i), 32'h5350_0000 + i);
    end
    foreach (all_modes[k])
      for (int i = 8; i < 13; i++) rd("R3 banked high", all_modes[k], 4'(i), 4'(12 - (i - 8)));

    // R4: six copies of indices 13 and 14
    foreach (all_modes[k]) begin
      if (k != 6) begin
        wr("R4 write sp", all_modes[k], 4'd13, 32'h1300_0000 + k);
        wr("R4 write lr", all_modes[k], 4'd14, 32'h1400_0000 + k);
      end
    end
    foreach (all_modes[k]) rd("R4 banked sp lr", all_modes[k], 4'd13, 4'd14);

    // R5: system and reserved values alias user
    wr("R5 write sys", M_SYS, 4'd13, 32'h5155_5155);
    rd("R5 user sees sys", M_USR, 4'd13, 4'd14);
    rd("R5 reserved 00000", 5'b00000, 4'd13, 4'd9);
    rd("R5 reserved 10100", 5'b10100, 4'd13, 4'd14);
    rd("R5 fiq unaffected", M_FIQ, 4'd13, 4'd14);

    // R6: same-cycle read returns old value, new value after the edge
    cyc("R6 read during write", M_USR, 4'd2, 4'd2, 1'b1, 4'd2, 32'h6666_0002, 1'b0, M_USR, '0);
    rd("R6 read after write", M_USR, 4'd2, 4'd2);
    chk("R6 new value explicit", rd_a_data, 32'h6666_0002);

    // R8: exception write independent of current mode
    cyc("R8 exc write svc", M_USR, 4'd14, 4'd14, 1'b0, 4'd0, '0, 1'b1, M_SVC, 32'h8888_0003);
    rd("R8 svc lr", M_SVC, 4'd14, 4'd13);
    rd("R8 usr lr untouched", M_USR, 4'd14, 4'd13);
    chk("R8 svc lr explicit", m_lr[3], 32'h8888_0003);

    // R9: collision, exception wins
    cyc("R9 collide", M_ABT, 4'd14, 4'd0, 1'b1, 4'd14, 32'h1111_1111, 1'b1, M_ABT, 32'h9999_9999);
    rd("R9 exc wins", M_ABT, 4'd14, 4'd14);
    chk("R9 exc wins explicit", rd_a_data, 32'h9999_9999);
    // R9: distinct targets, both land
    cyc("R9 both", M_USR, 4'd5, 4'd14, 1'b1, 4'd5, 32'h5555_0005, 1'b1, M_IRQ, 32'h2222_000E);
    rd("R9 both normal", M_USR, 4'd5, 4'd14);
    rd("R9 both exc", M_IRQ, 4'd14, 4'd5);
    // R9: normal write to a different bank's lr alongside exception
    cyc("R9 lr different banks", M_UND, 4'd14, 4'd0, 1'b1, 4'd14, 32'hAAAA_0005, 1'b1, M_FIQ, 32'hBBBB_0001);
    rd("R9 und lr", M_UND, 4'd14, 4'd14);
    rd("R9 fiq lr", M_FIQ, 4'd14, 4'd14);

    // R10: random traffic with independent ports
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] rm, em;
      rm = ($urandom_range(0, 9) == 0) ? 5'($urandom) : all_modes[$urandom_range(0, 6)];
      em = ($urandom_range(0, 9) == 0) ? 5'($urandom) : all_modes[$urandom_range(0, 6)];
      cyc("R10 random", rm, 4'($urandom), 4'($urandom),
          ($urandom_range(0, 2) != 0), 4'($urandom), $urandom,
          ($urandom_range(0, 4) == 0), em, $urandom);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule